// File: doc/BRIEF.md
# Hotspot Bank Switching Cartridge Mapper

This block places a 4 KB processor address window over a cartridge holding up to seven 4 KB ROM banks and a 256-byte RAM. The active bank changes whenever the processor touches one of a short run of trigger offsets near the top of the window. A read and a write have the same effect on the bank, so no data is ever written to make the switch. The RAM is reached through two separate 256-byte ranges: one is only for writing and one is only for reading. This suits a bus that has only a read/write line and no separate write-data decode on the cartridge.

All accesses are synchronous to `clk`. The chip-select marks a bus cycle, and `busWrite` tells whether that cycle is a write or a read. Read data appears on `rdData` one clock after the read cycle and holds until the next read. The ROM contents are computed by a fixed function of bank and offset, so no stored image is needed. The `sevenBanks` input chooses between six and seven usable banks. While `bankLock` is high the bank is frozen.

Top module: `hot_bank_mapper`

## Requirements
- R1: Only `addrIn[11:0]` (the window offset) is decoded; `addrIn[12]` has no effect on any behaviour.
- R2: Any cycle with `cartSel`=1, read or write, at offset 0xFF5+k (k = 0..5) makes bank k active at the next clock edge.
- R3: An access at offset 0xFFB makes bank 6 active when `sevenBanks`=1; when `sevenBanks`=0 it leaves the bank unchanged.
- R4: A write (`busWrite`=1) at offsets 0x000–0x0FF stores `wrData` into RAM location `addrIn[7:0]`.
- R5: A read at offsets 0x100–0x1FF puts RAM location `addrIn[7:0]` on `rdData` one clock later.
- R6: A write at offsets 0x100–0x1FF leaves every RAM location unchanged.
- R7: A read at offsets 0x000–0x0FF puts 0x00 on `rdData` one clock later.
- R8: A read at offset 0x200 or above puts the ROM byte of the bank active after that cycle on `rdData` one clock later. The ROM byte for bank b at offset o is o[7:0] XOR {b[2:0], 1'b0, o[11:8]}. A read at a trigger offset therefore returns data from the newly selected bank.
- R9: While `rstN`=0 the active bank becomes 0 and `rdData` becomes 0x00.
- R10: While `bankLock`=1, accesses at the trigger offsets leave the active bank unchanged.
- R11: `bankNum` always shows the active bank. A clock with `cartSel`=0 changes neither `bankNum` nor `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cartSel | input | 1 | Bus cycle in the cartridge window this clock |
| busWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| addrIn | input | 13 | Processor address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| bankLock | input | 1 | Freeze the active bank |
| sevenBanks | input | 1 | 1 = seven banks usable, 0 = six |
| bankNum | output | 3 | Active bank number |

## Verification
A bank switch and a data read can fall in the same cycle: a read at a trigger offset must return ROM from the bank it has just selected, not from the old one. The bench provokes this both with directed reads at every trigger offset and with random traffic that hits the trigger run under changing lock and bank-count settings. It judges each cycle against a behavioural model that applies the bank update before it forms the read byte. Lock raised in the same cycle as a trigger access is the second collision. Here the model expects the old bank to hold and its ROM to be returned.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  localparam int ADDR_W = 13;
  localparam int WIN_W  = 12;
  localparam int DATA_W = 8;
  localparam int BANK_W = 3;
  localparam int RAM_AW = 8;
  localparam int REGION_W = WIN_W - RAM_AW;

  typedef struct packed {
    logic              ramWrite;
    logic              ramRead;
    logic              romRead;
    logic              zeroRead;
    logic [BANK_W-1:0] romBank;
  } hbmStrobes_t;

  function automatic logic [DATA_W-1:0] romByte(logic [BANK_W-1:0] bank,
                                                logic [WIN_W-1:0] off);
    return off[DATA_W-1:0] ^ {bank, 1'b0, off[WIN_W-1:RAM_AW]};
  endfunction
endpackage

// File: rtl/hbm_control.sv
module hbm_control
  import hbm_pkg::*;
#(
  parameter logic [WIN_W-1:0] HOT_FIRST = 12'hFF5,
  parameter int               BANKS_MAX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cartSel,
  input  logic              busWrite,
  input  logic [WIN_W-1:0]  addrLow,
  input  logic              bankLock,
  input  logic              sevenBanks,
  output hbmStrobes_t       strobes,
  output logic [BANK_W-1:0] bankNum
);
  localparam logic [REGION_W-1:0] REG_WPORT = '0;
  localparam logic [REGION_W-1:0] REG_RPORT = REGION_W'(1);

  logic [BANKS_MAX-1:0] hotGo;
  logic [BANK_W-1:0]    nextBank;
  logic [REGION_W-1:0]  region;

  // Trigger compare per bank; the top bank is gated by the bank-count input.
  genvar b;
  generate
    for (b = 0; b < BANKS_MAX; b++) begin : g_hot
      localparam logic [WIN_W-1:0] HOT_ADDR = HOT_FIRST + WIN_W'(b);
      if (b == BANKS_MAX - 1) begin : g_last
        assign hotGo[b] = (addrLow == HOT_ADDR) && sevenBanks;
      end else begin : g_base
        assign hotGo[b] = (addrLow == HOT_ADDR);
      end
    end
  endgenerate

  always_comb begin
    nextBank = bankNum;
    if (cartSel && !bankLock) begin
      for (int k = 0; k < BANKS_MAX; k++) begin
        if (hotGo[k]) nextBank = BANK_W'(k);
      end
    end
  end

  assign region = addrLow[WIN_W-1:RAM_AW];

  always_comb begin
    strobes.ramWrite = cartSel && busWrite && (region == REG_WPORT);
    strobes.zeroRead = cartSel && !busWrite && (region == REG_WPORT);
    strobes.ramRead  = cartSel && !busWrite && (region == REG_RPORT);
    strobes.romRead  = cartSel && !busWrite && (region > REG_RPORT);
    strobes.romBank  = nextBank;
  end

  always_ff @(posedge clk) begin
    if (!rstN) bankNum <= '0;
    else       bankNum <= nextBank;
  end
endmodule

// File: rtl/hbm_datapath.sv
module hbm_datapath
  import hbm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hbmStrobes_t       strobes,
  input  logic [WIN_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] ramArr [RAM_DEPTH];
  logic [RAM_AW-1:0] ramIdx;

  assign ramIdx = addrLow[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (strobes.ramWrite) ramArr[ramIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.ramRead)  rdData <= ramArr[ramIdx];
    else if (strobes.zeroRead) rdData <= '0;
    else if (strobes.romRead)  rdData <= romByte(strobes.romBank, addrLow);
  end
endmodule

// File: rtl/hot_bank_mapper.sv
module hot_bank_mapper
  import hbm_pkg::*;
#(
  parameter logic [WIN_W-1:0] HOT_FIRST = 12'hFF5,
  parameter int               BANKS_MAX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cartSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              bankLock,
  input  logic              sevenBanks,
  output logic [BANK_W-1:0] bankNum
);
  hbmStrobes_t      strobes;
  logic [WIN_W-1:0] addrLow;

  assign addrLow = addrIn[WIN_W-1:0];

  hbm_control #(.HOT_FIRST(HOT_FIRST), .BANKS_MAX(BANKS_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .cartSel(cartSel), .busWrite(busWrite),
    .addrLow(addrLow), .bankLock(bankLock), .sevenBanks(sevenBanks),
    .strobes(strobes), .bankNum(bankNum)
  );

  hbm_datapath u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrLow(addrLow),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/hbm_checker.sv
module hbm_checker
  import hbm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cartSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] addrIn,
  input logic              bankLock,
  input logic              sevenBanks,
  input logic [DATA_W-1:0] rdData,
  input logic [BANK_W-1:0] bankNum
);
  a_r9_reset_bank: assert property (@(posedge clk)
    !rstN |=> (bankNum == '0) && (rdData == '0));

  a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    bankLock |=> $stable(bankNum));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cartSel |=> $stable(bankNum) && $stable(rdData));

  a_r2_select_bank2: assert property (@(posedge clk) disable iff (!rstN)
    cartSel && !bankLock && (addrIn[11:0] == 12'hFF7) |=> bankNum == 3'd2);

  a_r3_bank6_enabled: assert property (@(posedge clk) disable iff (!rstN)
    cartSel && !bankLock && sevenBanks && (addrIn[11:0] == 12'hFFB)
      |=> bankNum == 3'd6);

  a_r3_bank6_disabled: assert property (@(posedge clk) disable iff (!rstN)
    cartSel && !sevenBanks && (addrIn[11:0] == 12'hFFB) |=> $stable(bankNum));

  a_r7_write_port_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    cartSel && !busWrite && ((addrIn & 13'h0F00) == 13'h0000) |=> rdData == '0);
endmodule

bind hot_bank_mapper hbm_checker u_chk (
  .clk(clk), .rstN(rstN), .cartSel(cartSel), .busWrite(busWrite),
  .addrIn(addrIn), .bankLock(bankLock), .sevenBanks(sevenBanks),
  .rdData(rdData), .bankNum(bankNum)
);

// File: tb/hot_bank_mapper_test.sv
`timescale 1ns/1ps
module hot_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cartSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [12:0] addrIn = '0;
  logic [7:0]  wrData = '0;
  logic        bankLock = 1'b0;
  logic        sevenBanks = 1'b1;
  logic [7:0]  rdData;
  logic [2:0]  bankNum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hot_bank_mapper uut (
    .clk(clk), .rstN(rstN), .cartSel(cartSel), .busWrite(busWrite),
    .addrIn(addrIn), .wrData(wrData), .rdData(rdData),
    .bankLock(bankLock), .sevenBanks(sevenBanks), .bankNum(bankNum)
  );

  // Behavioural reference model
  int    mBank = 0;
  int    mRd = 0;
  int    mRam [256];
  string tagBank = "R9";
  string tagRd = "R9";

  function automatic int romRef(int bank, int off);
    return (off & 255) ^ (((bank & 7) << 5) | ((off >> 8) & 15));
  endfunction

  always @(posedge clk) begin
    int off, nb;
    if (!rstN) begin
      mBank = 0; mRd = 0; tagBank = "R9"; tagRd = "R9";
    end else if (cartSel) begin
      off = int'(addrIn) & 12'hFFF;
      nb = mBank;
      if (off >= 12'hFF5 && off <= 12'hFFB) begin
        tagBank = (off == 12'hFFB) ? "R3" : "R2";
        if (bankLock) tagBank = "R10";
        else if (off <= 12'hFFA) nb = off - 12'hFF5;
        else if (sevenBanks) nb = 6;
      end else tagBank = "R11";
      if (busWrite) begin
        if (off < 12'h100) mRam[off] = int'(wrData);
      end else if (off < 12'h100) begin
        mRd = 0; tagRd = "R7";
      end else if (off < 12'h200) begin
        mRd = mRam[off & 255]; tagRd = "R5";
      end else begin
        mRd = romRef(nb, off); tagRd = "R8";
      end
      mBank = nb;
    end else tagBank = "R11";
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(bankNum) != mBank) begin
        errors++;
        $display("FAIL %s bankNum actual %0d expected %0d", tagBank, bankNum, mBank);
      end
      checks++;
      if (int'(rdData) != mRd) begin
        errors++;
        $display("FAIL %s rdData actual %0h expected %0h", tagRd, rdData, mRd);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic acc(logic w, logic [12:0] a, logic [7:0] d);
    busWrite = w; addrIn = a; wrData = d; cartSel = 1'b1;
    @(negedge clk);
    cartSel = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", int'(bankNum), 0);
    chk("R9", int'(rdData), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 256; i++) acc(1'b1, 13'(i), 8'(i ^ 8'h5A));
    acc(1'b0, 13'h105, 8'h00);
    chk("R4", int'(rdData), 8'h05 ^ 8'h5A);
    acc(1'b0, 13'h1FF, 8'h00);
    chk("R5", int'(rdData), 8'hFF ^ 8'h5A);

    acc(1'b1, 13'h133, 8'hEE);
    acc(1'b0, 13'h133, 8'h00);
    chk("R6", int'(rdData), 8'h33 ^ 8'h5A);
    acc(1'b0, 13'h033, 8'h00);
    chk("R6", int'(rdData), 0);
    acc(1'b0, 13'h042, 8'h00);
    chk("R7", int'(rdData), 0);

    for (int b = 0; b < 6; b++) begin
      acc(1'b0, 13'(12'hFF5 + b), 8'h00);
      chk("R2", int'(bankNum), b);
      chk("R8", int'(rdData), romRef(b, 12'hFF5 + b));
    end
    acc(1'b1, 13'hFF7, 8'h99);
    chk("R2", int'(bankNum), 2);
    acc(1'b0, 13'h345, 8'h00);
    chk("R8", int'(rdData), romRef(2, 12'h345));

    sevenBanks = 1'b0;
    acc(1'b0, 13'hFFB, 8'h00);
    chk("R3", int'(bankNum), 2);
    sevenBanks = 1'b1;
    acc(1'b1, 13'hFFB, 8'h00);
    chk("R3", int'(bankNum), 6);

    bankLock = 1'b1;
    acc(1'b0, 13'hFF5, 8'h00);
    chk("R10", int'(bankNum), 6);
    chk("R10", int'(rdData), romRef(6, 12'hFF5));
    bankLock = 1'b0;

    acc(1'b0, 13'h1FF8, 8'h00);
    chk("R1", int'(bankNum), 3);
    acc(1'b0, 13'h1105, 8'h00);
    chk("R1", int'(rdData), 8'h05 ^ 8'h5A);
    acc(1'b1, 13'h1010, 8'h77);
    acc(1'b0, 13'h0110, 8'h00);
    chk("R1", int'(rdData), 8'h77);

    busWrite = 1'b0; addrIn = 13'hFF6;
    repeat (3) @(negedge clk);
    chk("R11", int'(bankNum), 3);
    chk("R11", int'(rdData), 8'h77);

    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [11:0] off;
      r = int'($urandom % 8);
      case (r)
        0, 1: off = 12'($urandom % 256);
        2, 3: off = 12'(256 + $urandom % 256);
        4:    off = 12'(12'hFF4 + $urandom % 9);
        default: off = 12'(512 + $urandom % 3584);
      endcase
      bankLock = (($urandom % 8) == 0);
      if (($urandom % 32) == 0) sevenBanks = ~sevenBanks;
      busWrite = $urandom % 2 == 0;
      addrIn = {1'($urandom % 2), off};
      wrData = 8'($urandom);
      cartSel = ($urandom % 4) != 0;
      @(negedge clk);
    end
    cartSel = 1'b0;
    bankLock = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule